// File: doc/BRIEF.md
# Infrared SIR Pulse Encoder

This block turns the transmit line of a UART into short, active-high infrared drive pulses of the kind used by serial infrared links. A zero bit on the line gives one narrow pulse at the start of that bit. A one bit, which covers idle and stop bits, leaves the drive low. The block runs on the oscillator clock. Its timing comes from two sources: a 16x baud tick supplied by the UART's baud generator, and a 5-bit divisor that scales the oscillator clock down to a slower reference rate.

A mode input selects how the pulse width is set. In proportional mode the width is three sixteenths of a bit. In fixed mode the width is three periods of the divided reference, so it stays the same at every baud rate. The reference is a single-cycle enable in the oscillator domain, and no derived clock is used. The mode and the divisor are sampled only at a bit boundary, so changing them in the middle of a bit never cuts a pulse short or lengthens it. A divisor of 0 to 3 is raised to 4.

Top module: `irda_sir_encoder`

## Requirements
- R1: The mode input is sampled at each bit boundary. A value of 1 selects proportional width and a value of 0 selects fixed width for the bit that starts there.
- R2: In proportional mode, a zero bit drives ir_out high from the clock cycle after its boundary tick. It stays high for exactly 3 baud tick periods and drops in the cycle after the third following tick.
- R3: In fixed mode, a zero bit drives ir_out high from the clock cycle after its boundary tick for exactly 3*D oscillator cycles. D is the effective divisor sampled at that boundary.
- R4: The effective divisor is the value of div_sel when that value is 4 or more, and 4 otherwise. So values 0 to 3 give a fixed pulse of 12 cycles.
- R5: A one bit (tx_in = 1) never starts a pulse, and ir_out stays low for the whole of such a bit.
- R6: A bit boundary is a baud tick at which tx_in differs from the level held for the current bit, or the 16th tick since the previous boundary. Each bit in a run of zero bits therefore gives its own pulse.
- R7: A change of mode_sel or div_sel during a bit has no effect on the width of the pulse already started. It applies from the next boundary.
- R8: While reset is asserted, and after it is released until the first zero-bit boundary, ir_out is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | Single-cycle 16x baud tick from the baud generator |
| tx_in | input | 1 | UART transmit line, high when idle |
| mode_sel | input | 1 | Width mode: 1 proportional, 0 fixed |
| div_sel | input | 5 | Oscillator divisor for the fixed-mode reference |
| ir_out | output | 1 | Active-high infrared drive pulse |

## Verification
Suppose the sub-bit counter or the held bit level goes wrong. Boundaries then move off the UART's bit grid, and a run of zeros shows it within one bit time: a pulse is missing, an extra one appears, or a one bit carries a pulse. Suppose instead the prescaler, the clamp or the pulse counters go wrong. Then a pulse ends at the wrong time, and the error is visible at the falling edge of that same pulse as a width other than 24 cycles (proportional) or 3*D cycles (fixed). If a latch for mode or divisor passes its value through during the bit, a change made in the middle of a bit alters the pulse already running. This is checked against the setting that was present at the boundary.

// File: rtl/irda_pkg.sv
package irda_pkg;
   typedef enum logic {
      PW_FIXED = 1'b0,
      PW_PROP  = 1'b1
   } pw_mode_e;
endpackage

// File: rtl/irda_bit_timer.sv
module irda_bit_timer #(
   parameter int DIV_W   = 5,
   parameter int DIV_MIN = 4,
   parameter int DIV_RST = 15,
   parameter int SUB_W   = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  tick_i,
   input  logic                  tx_i,
   input  irda_pkg::pw_mode_e    mode_i,
   input  logic [DIV_W-1:0]      div_i,
   output logic                  bound_o,
   output logic                  bit_o,
   output irda_pkg::pw_mode_e    mode_o,
   output logic [DIV_W-1:0]      div_o
);
   localparam int SUB_LAST = (1 << SUB_W) - 1;

   logic             bit_q;
   logic [SUB_W-1:0] sub_q;
   logic [DIV_W-1:0] div_floor;
   irda_pkg::pw_mode_e mode_q;
   logic [DIV_W-1:0]   div_q;

   assign div_floor = (div_i < DIV_W'(DIV_MIN)) ? DIV_W'(DIV_MIN) : div_i;
   assign bound_o   = tick_i && ((tx_i != bit_q) || (sub_q == SUB_W'(SUB_LAST)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_q  <= 1'b1;
         sub_q  <= '0;
         mode_q <= irda_pkg::PW_PROP;
         div_q  <= DIV_W'(DIV_RST);
      end else if (bound_o) begin
         bit_q  <= tx_i;
         sub_q  <= '0;
         mode_q <= mode_i;
         div_q  <= div_floor;
      end else if (tick_i) begin
         sub_q  <= sub_q + 1'b1;
      end
   end

   assign bit_o  = bit_q;
   assign mode_o = mode_q;
   assign div_o  = div_q;

   // R4: the divisor in use never falls below the floor
   a_r4_div_floor: assert property (@(posedge clk) disable iff (!rst_n)
      div_q >= DIV_W'(DIV_MIN));

   // R7: settings move only at a boundary
   a_r7_hold_mid_bit: assert property (@(posedge clk) disable iff (!rst_n)
      !bound_o |=> ($stable(mode_q) && $stable(div_q)));
endmodule

// File: rtl/irda_prescaler.sv
module irda_prescaler #(
   parameter int DIV_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             ref_en_o
);
   logic [DIV_W-1:0] cnt_q;
   logic             at_end;

   assign at_end   = (cnt_q == div_i - 1'b1);
   assign ref_en_o = !restart_i && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt_q <= '0;
      else if (restart_i) cnt_q <= '0;
      else if (at_end)    cnt_q <= '0;
      else                cnt_q <= cnt_q + 1'b1;
   end

   // R3: the reference enable is a lone single-cycle strobe
   a_r3_ref_single: assert property (@(posedge clk) disable iff (!rst_n)
      ref_en_o |=> !ref_en_o);
endmodule

// File: rtl/irda_pulse_gen.sv
module irda_pulse_gen #(
   parameter int PROP_TICKS = 3,
   parameter int FIXED_REFS = 3,
   parameter bit HAS_FIXED  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bound_i,
   input  logic               tx_i,
   input  irda_pkg::pw_mode_e mode_i,
   input  logic               tick_i,
   input  logic               ref_en_i,
   output logic               pulse_o
);
   localparam int CNT_MAX = (PROP_TICKS > FIXED_REFS) ? PROP_TICKS : FIXED_REFS;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);

   logic             zero_start;
   logic             prop_act;
   logic [CNT_W-1:0] prop_cnt;
   logic             fix_act;

   assign zero_start = bound_i && !tx_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prop_act <= 1'b0;
         prop_cnt <= '0;
      end else if (bound_i) begin
         prop_act <= zero_start && (mode_i == irda_pkg::PW_PROP);
         prop_cnt <= '0;
      end else if (prop_act && tick_i) begin
         if (prop_cnt == CNT_W'(PROP_TICKS - 1)) prop_act <= 1'b0;
         else                                     prop_cnt <= prop_cnt + 1'b1;
      end
   end

   generate
      if (HAS_FIXED) begin : g_fixed
         logic [CNT_W-1:0] fix_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               fix_act <= 1'b0;
               fix_cnt <= '0;
            end else if (bound_i) begin
               fix_act <= zero_start && (mode_i == irda_pkg::PW_FIXED);
               fix_cnt <= '0;
            end else if (fix_act && ref_en_i) begin
               if (fix_cnt == CNT_W'(FIXED_REFS - 1)) fix_act <= 1'b0;
               else                                    fix_cnt <= fix_cnt + 1'b1;
            end
         end
      end else begin : g_no_fixed
         assign fix_act = 1'b0;
      end
   endgenerate

   assign pulse_o = prop_act | fix_act;

   // R1: the two width paths never drive at once
   a_r1_one_path: assert property (@(posedge clk) disable iff (!rst_n)
      !(prop_act && fix_act));
endmodule

// File: rtl/irda_sir_encoder.sv
module irda_sir_encoder #(
   parameter int DIV_W      = 5,
   parameter int DIV_MIN    = 4,
   parameter int DIV_RST    = 15,
   parameter int SUB_W      = 4,
   parameter int PROP_TICKS = 3,
   parameter int FIXED_REFS = 3,
   parameter bit HAS_FIXED  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             baud_tick,
   input  logic             tx_in,
   input  logic             mode_sel,
   input  logic [DIV_W-1:0] div_sel,
   output logic             ir_out
);
   localparam int HW = DIV_W + 3;

   generate
      if (DIV_MIN < 2 || DIV_MIN >= (1 << DIV_W)) begin : g_bad_min
         $error("DIV_MIN out of range for DIV_W");
      end
      if (DIV_RST < DIV_MIN || DIV_RST >= (1 << DIV_W)) begin : g_bad_rst
         $error("DIV_RST out of range");
      end
      if (PROP_TICKS < 1 || PROP_TICKS >= (1 << SUB_W)) begin : g_bad_prop
         $error("PROP_TICKS must fit inside one bit");
      end
      if (FIXED_REFS < 1) begin : g_bad_fix
         $error("FIXED_REFS must be positive");
      end
   endgenerate

   logic               bound;
   logic               bit_lvl;
   irda_pkg::pw_mode_e mode_q;
   logic [DIV_W-1:0]   div_q;
   logic               ref_en;

   irda_bit_timer #(.DIV_W(DIV_W), .DIV_MIN(DIV_MIN), .DIV_RST(DIV_RST), .SUB_W(SUB_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (baud_tick),
      .tx_i    (tx_in),
      .mode_i  (irda_pkg::pw_mode_e'(mode_sel)),
      .div_i   (div_sel),
      .bound_o (bound),
      .bit_o   (bit_lvl),
      .mode_o  (mode_q),
      .div_o   (div_q)
   );

   irda_prescaler #(.DIV_W(DIV_W)) u_presc (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart_i (bound),
      .div_i     (div_q),
      .ref_en_o  (ref_en)
   );

   irda_pulse_gen #(.PROP_TICKS(PROP_TICKS), .FIXED_REFS(FIXED_REFS), .HAS_FIXED(HAS_FIXED)) u_pulse (
      .clk      (clk),
      .rst_n    (rst_n),
      .bound_i  (bound),
      .tx_i     (tx_in),
      .mode_i   (irda_pkg::pw_mode_e'(mode_sel)),
      .tick_i   (baud_tick),
      .ref_en_i (ref_en),
      .pulse_o  (ir_out)
   );

   // width observers for the checks below
   logic [HW-1:0] hi_cyc;
   logic [HW-1:0] hi_ticks;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_cyc   <= '0;
         hi_ticks <= '0;
      end else if (ir_out) begin
         hi_cyc   <= hi_cyc + 1'b1;
         hi_ticks <= hi_ticks + HW'(baud_tick);
      end else begin
         hi_cyc   <= '0;
         hi_ticks <= '0;
      end
   end

   // R5: a one bit keeps the drive dark
   a_r5_one_dark: assert property (@(posedge clk) disable iff (!rst_n)
      bit_lvl |-> !ir_out);

   // R6: a pulse only begins right after a zero-bit boundary
   a_r6_start_on_bound: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ir_out) |-> ($past(bound) && !bit_lvl));

   // R2: a proportional pulse spans three ticks
   a_r2_prop_width: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ir_out) && !$past(bound) && mode_q == irda_pkg::PW_PROP) |->
         (hi_ticks == HW'(PROP_TICKS)));

   // R3: a fixed pulse spans FIXED_REFS reference periods
   a_r3_fixed_width: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ir_out) && !$past(bound) && mode_q == irda_pkg::PW_FIXED) |->
         (hi_cyc == HW'(FIXED_REFS) * HW'(div_q)));
endmodule

// File: tb/irda_sir_encoder_tb.sv
module irda_sir_encoder_tb_top;
   localparam int TICK_P = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       baud_tick = 1'b0;
   logic       tx_in = 1'b1;
   logic       mode_sel = 1'b1;
   logic [4:0] div_sel = 5'd15;
   logic       ir_out;

   int errors = 0;
   int checks = 0;
   int rises  = 0;
   int exp_q[$];
   string tag_q[$];
   bit done = 1'b0;

   irda_sir_encoder dut_i (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_in(tx_in),
      .mode_sel(mode_sel), .div_sel(div_sel), .ir_out(ir_out)
   );

   always #10 clk = ~clk;

   initial begin : tick_gen
      int tc = 0;
      forever begin
         @(negedge clk);
         tc = (tc == TICK_P - 1) ? 0 : tc + 1;
         baud_tick = (tc == TICK_P - 1);
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   // monitor: measure each pulse and compare with the scoreboard
   initial begin : monitor
      int width = 0;
      bit prev = 1'b0;
      forever begin
         @(negedge clk);
         if (ir_out && !prev) rises++;
         if (ir_out) width++;
         else if (width > 0) begin
            if (exp_q.size() == 0) chk(1'b0, "R5 unexpected pulse", width, 0);
            else begin
               int e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               chk(width == e, t, width, e);
            end
            width = 0;
         end
         prev = ir_out;
      end
   end

   task automatic wait_tick();
      do @(posedge clk); while (!baud_tick);
   endtask

   function automatic int exp_width(input bit m, input logic [4:0] d);
      int de;
      de = (d < 5'd4) ? 4 : int'(d);
      return m ? 3 * TICK_P : 3 * de;
   endfunction

   // driver: one bit of 16 ticks; settings changed after the second tick
   task automatic send_bit(input bit b, input bit m, input logic [4:0] d,
                           input bit m2, input logic [4:0] d2, input string req);
      int r0;
      wait_tick();
      @(negedge clk);
      tx_in = b; mode_sel = m; div_sel = d;
      if (!b) begin
         exp_q.push_back(exp_width(m, d));
         tag_q.push_back(req);
      end
      r0 = rises;
      wait_tick();
      wait_tick();
      @(negedge clk);
      mode_sel = m2; div_sel = d2;
      repeat (13) wait_tick();
      if (b) chk(rises == r0, {req, " one bit dark (R5)"}, rises - r0, 0);
   endtask

   task automatic send_plain(input bit b, input bit m, input logic [4:0] d, input string req);
      send_bit(b, m, d, m, d, req);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      chk(ir_out == 1'b0, "R8 in reset", int'(ir_out), 0);
      rst_n = 1'b1;
      repeat (40) begin
         @(negedge clk);
         chk(ir_out == 1'b0, "R8 after reset idle", int'(ir_out), 0);
      end
      // idle ones in both modes
      send_plain(1'b1, 1'b1, 5'd15, "R5 idle prop");
      send_plain(1'b1, 1'b0, 5'd15, "R5 idle fixed");
      // proportional: start bit, run of zeros, alternation
      send_plain(1'b0, 1'b1, 5'd15, "R2 start bit");
      send_plain(1'b0, 1'b1, 5'd15, "R6 zero run 1");
      send_plain(1'b0, 1'b1, 5'd15, "R6 zero run 2");
      send_plain(1'b1, 1'b1, 5'd15, "R5 prop one");
      send_plain(1'b0, 1'b1, 5'd15, "R2 after one");
      send_plain(1'b1, 1'b1, 5'd15, "R5 stop");
      // fixed mode at several divisors
      send_plain(1'b0, 1'b0, 5'd22, "R3 div 22");
      send_plain(1'b0, 1'b0, 5'd13, "R3 div 13");
      send_plain(1'b0, 1'b0, 5'd4,  "R3 div 4");
      send_plain(1'b0, 1'b0, 5'd31, "R3 div 31");
      send_plain(1'b1, 1'b0, 5'd31, "R5 fixed one");
      // clamp
      send_plain(1'b0, 1'b0, 5'd0, "R4 div 0");
      send_plain(1'b0, 1'b0, 5'd3, "R4 div 3");
      send_plain(1'b0, 1'b0, 5'd5, "R4 div 5");
      // mode selection alternating bit by bit
      send_plain(1'b0, 1'b1, 5'd9, "R1 prop pick");
      send_plain(1'b0, 1'b0, 5'd9, "R1 fixed pick");
      send_plain(1'b0, 1'b1, 5'd9, "R1 prop again");
      // mid-bit changes leave the running pulse alone
      send_bit(1'b0, 1'b1, 5'd9,  1'b0, 5'd31, "R7 prop to fixed");
      send_bit(1'b0, 1'b0, 5'd4,  1'b0, 5'd31, "R7 div grow");
      send_bit(1'b0, 1'b0, 5'd31, 1'b1, 5'd4,  "R7 fixed to prop");
      send_bit(1'b1, 1'b1, 5'd4,  1'b0, 5'd20, "R7 one bit change");
      send_plain(1'b0, 1'b0, 5'd20, "R7 applied next");
      send_plain(1'b1, 1'b0, 5'd20, "R5 final stop");
      send_plain(1'b1, 1'b1, 5'd15, "R5 final idle");
      chk(exp_q.size() == 0, "R6 all pulses seen", exp_q.size(), 0);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule